// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog timer with a small register port. It advances on a slow tick enable, nominally 32 kHz, that arrives in the system clock domain. An up-counter runs from a programmable reload value. An optional power-of-two prescaler sits in front of it. When the counter wraps past its all-ones value, the block raises a one-cycle reset request and reloads the counter.

Software keeps the system alive by writing a trigger register with a value that differs from the last one written. That copies the reload value into the counter. The timer can be halted or restarted only by writing two key words, in order, to a dedicated key register.

Every writable register is posted. A write lands in a holding slot and takes effect after a fixed number of slow ticks. A per-register pending bit tells software when the write has not yet landed.

Top module: `keyseq_wdt`

## Requirements
- R1: After reset the timer is running. The counter and the reload register both hold DEFAULT_LOAD. Control, pending status and the reset request are all zero.
- R2: The revision register (address 0) reads REV_CODE in bits 7:0 and zero above. Writes to it are ignored.
- R3: Each write is posted, and on the next cycle it sets a pending bit. The bits sit in the status register (address 6): bit 0 for control (address 1), bit 2 for reload (address 2), bit 3 for trigger (address 4) and bit 4 for key (address 5). The write takes effect on the SYNC_TICKS-th tick after it is accepted, and its pending bit clears on that same edge. A new write to the same register while it is pending replaces the data and restarts the tick count.
- R4: While the timer runs with the prescaler off, the counter (address 3) rises by exactly one per tick.
- R5: The control register has a prescaler enable in bit 5 and an exponent k in bits 4:2. When enabled, the counter steps once every 2^k ticks. The prescale phase restarts when a control write takes effect. The tick on which the write lands still uses the old setting.
- R6: A step from the all-ones counter value loads the reload register value instead. On that edge the reset request goes high, for exactly one cycle.
- R7: A trigger write that takes effect copies the reload register into the counter, but only if its value differs from the previous trigger value. The previous value starts at zero after reset. Writing the same value again changes nothing, and a reload beats a count step on the same tick.
- R8: Key word 0xAAAA followed by 0x5555, as consecutive key writes, stops the counter. The tick that lands the second word still counts.
- R9: Key word 0xBBBB followed by 0x4444, as consecutive key writes, starts the counter again. The tick that lands the second word does not yet count.
- R10: A second key word without its matching first word, or with any other key write between the two, leaves the run state unchanged.
- R11: The counter register is read-only. Writes to it are ignored and set no pending bit.
- R12: Read data is registered: reg_rdata shows the register selected by reg_addr one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle slow tick enable (nominally 32 kHz) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| wdt_rst_req | output | 1 | One-cycle reset request on counter wrap |

## Verification
The bench builds the block with DEFAULT_LOAD set 64 counts below the wrap point and REV_CODE 0x5C. The tick enable stays under bench control, one pulse at a time. With this setup the wrap and its reset pulse can be reached within a few dozen ticks. Every posted write, prescale phase and key-sequence edge then falls on a tick the bench can count exactly. Near-top reload values are loaded through the trigger path, so the wrap reload uses a value other than the reset default.

// File: rtl/keyseq_wdt_pkg.sv
package keyseq_wdt_pkg;

  // Register word addresses
  localparam logic [2:0] A_REV   = 3'd0;
  localparam logic [2:0] A_CTRL  = 3'd1;
  localparam logic [2:0] A_LOAD  = 3'd2;
  localparam logic [2:0] A_COUNT = 3'd3;
  localparam logic [2:0] A_TRIG  = 3'd4;
  localparam logic [2:0] A_KEY   = 3'd5;
  localparam logic [2:0] A_PEND  = 3'd6;

  // Posted slots
  localparam int NSLOT  = 4;
  localparam int S_CTRL = 0;
  localparam int S_LOAD = 1;
  localparam int S_TRIG = 2;
  localparam int S_KEY  = 3;

  localparam logic [2:0] SLOT_ADDR [NSLOT] = '{A_CTRL, A_LOAD, A_TRIG, A_KEY};
  localparam int         PEND_POS  [NSLOT] = '{0, 2, 3, 4};
  localparam int         PEND_W    = 5;

  // Control field layout
  localparam int CTRL_W   = 6;
  localparam int PSC_EN_B = 5;
  localparam int EXP_LO   = 2;
  localparam int EXP_W    = 3;

  // Key words
  localparam logic [15:0] KEY_STOP1  = 16'hAAAA;
  localparam logic [15:0] KEY_STOP2  = 16'h5555;
  localparam logic [15:0] KEY_START1 = 16'hBBBB;
  localparam logic [15:0] KEY_START2 = 16'h4444;

  typedef enum logic [1:0] {
    ARM_NONE  = 2'd0,
    ARM_STOP  = 2'd1,
    ARM_START = 2'd2
  } arm_t;

endpackage

// File: rtl/kw_post_slot.sv
module kw_post_slot #(
  parameter int DATA_W     = 32,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pend_o,
  output logic              commit_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int TCNT_W = $clog2(SYNC_TICKS + 1);
  localparam logic [TCNT_W-1:0] TLAST = TCNT_W'(SYNC_TICKS - 1);

  logic              pend_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [DATA_W-1:0] data_q;

  assign commit_o = pend_q && tick_en_i && !wr_i && (tcnt_q == TLAST);
  assign pend_o   = pend_q;
  assign data_o   = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      tcnt_q <= '0;
      data_q <= '0;
    end else if (wr_i) begin
      pend_q <= 1'b1;
      tcnt_q <= '0;
      data_q <= wdata_i;
    end else if (pend_q && tick_en_i) begin
      if (tcnt_q == TLAST) begin
        pend_q <= 1'b0;
        tcnt_q <= '0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  // R3: pending only drops on a slow tick
  p_pend_fall_tick_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> $past(tick_en_i));

  // R3: after a commit the slot is idle
  p_commit_clears_r3: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !pend_q);

endmodule

// File: rtl/kw_key_fsm.sv
module kw_key_fsm
  import keyseq_wdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] key_i,
  output logic              run_o
);

  localparam logic [DATA_W-1:0] K_S1 = DATA_W'(KEY_STOP1);
  localparam logic [DATA_W-1:0] K_S2 = DATA_W'(KEY_STOP2);
  localparam logic [DATA_W-1:0] K_G1 = DATA_W'(KEY_START1);
  localparam logic [DATA_W-1:0] K_G2 = DATA_W'(KEY_START2);

  arm_t arm_q;
  logic run_q;

  assign run_o = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= ARM_NONE;
      run_q <= 1'b1;
    end else if (commit_i) begin
      if (key_i == K_S1) begin
        arm_q <= ARM_STOP;
      end else if (key_i == K_G1) begin
        arm_q <= ARM_START;
      end else if (key_i == K_S2) begin
        if (arm_q == ARM_STOP) run_q <= 1'b0;
        arm_q <= ARM_NONE;
      end else if (key_i == K_G2) begin
        if (arm_q == ARM_START) run_q <= 1'b1;
        arm_q <= ARM_NONE;
      end else begin
        arm_q <= ARM_NONE;
      end
    end
  end

  // R10: run state only moves on a landed key write
  p_run_on_commit_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(run_q) |-> $past(commit_i));

  // R8: stopping is caused by the second stop word
  p_stop_by_key_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> $past(key_i == K_S2));

  // R9: starting is caused by the second start word
  p_start_by_key_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> $past(key_i == K_G2));

endmodule

// File: rtl/kw_up_counter.sv
module kw_up_counter
  import keyseq_wdt_pkg::*;
#(
  parameter int              DATA_W       = 32,
  parameter logic [DATA_W-1:0] DEFAULT_LOAD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en_i,
  input  logic              run_i,
  input  logic              psc_en_i,
  input  logic [EXP_W-1:0]  psc_exp_i,
  input  logic              ctrl_commit_i,
  input  logic              reload_i,
  input  logic [DATA_W-1:0] load_i,
  output logic [DATA_W-1:0] count_o,
  output logic              rst_req_o
);

  localparam int PSC_W = (1 << EXP_W) - 1;

  logic [DATA_W-1:0] cnt_q;
  logic [PSC_W-1:0]  psc_q;
  logic [PSC_W-1:0]  psc_lim;
  logic              req_q;
  logic              psc_hit;
  logic              step;

  always_comb begin
    psc_lim = '0;
    for (int i = 0; i < PSC_W; i++) begin
      psc_lim[i] = (i < int'(psc_exp_i));
    end
  end

  assign psc_hit   = (psc_q == psc_lim);
  assign step      = tick_en_i && run_i && (!psc_en_i || psc_hit);
  assign count_o   = cnt_q;
  assign rst_req_o = req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q <= '0;
    end else if (ctrl_commit_i) begin
      psc_q <= '0;
    end else if (tick_en_i && run_i && psc_en_i) begin
      psc_q <= psc_hit ? '0 : psc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= DEFAULT_LOAD;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (reload_i) begin
        cnt_q <= load_i;
      end else if (step) begin
        if (&cnt_q) begin
          cnt_q <= load_i;
          req_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R6: reset request lasts one cycle
  p_req_single_r6: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);

  // R6: wrap loads the reload value
  p_wrap_reload_r6: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (cnt_q == $past(load_i)));

  // R8: a stopped counter without reload holds
  p_hold_stopped_r8: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !reload_i) |=> $stable(cnt_q));

  // R4: ordinary changes are single steps
  p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cnt_q) && !$past(reload_i) && !req_q) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/keyseq_wdt.sv
module keyseq_wdt
  import keyseq_wdt_pkg::*;
#(
  parameter int                DATA_W       = 32,
  parameter int                ADDR_W       = 3,
  parameter int                SYNC_TICKS   = 2,
  parameter logic [7:0]        REV_CODE     = 8'h31,
  parameter logic [DATA_W-1:0] DEFAULT_LOAD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wdt_rst_req
);

  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'({CTRL_W{1'b1}});
  localparam logic [DATA_W-1:0] REV_WORD  = DATA_W'(REV_CODE);

  logic [NSLOT-1:0]             slot_wr;
  logic [NSLOT-1:0]             slot_pend;
  logic [NSLOT-1:0]             slot_commit;
  logic [NSLOT-1:0][DATA_W-1:0] slot_data;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] trig_q;
  logic [DATA_W-1:0] count;
  logic [PEND_W-1:0] pend_word;
  logic [DATA_W-1:0] rdata_q;
  logic              run;
  logic              trig_reload;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_wr[g] = reg_we && (reg_addr == ADDR_W'(SLOT_ADDR[g]));
    kw_post_slot #(
      .DATA_W     (DATA_W),
      .SYNC_TICKS (SYNC_TICKS)
    ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .tick_en_i (tick_en),
      .wr_i      (slot_wr[g]),
      .wdata_i   (reg_wdata),
      .pend_o    (slot_pend[g]),
      .commit_o  (slot_commit[g]),
      .data_o    (slot_data[g])
    );
  end

  assign trig_reload = slot_commit[S_TRIG] && (slot_data[S_TRIG] != trig_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= DEFAULT_LOAD;
      trig_q <= '0;
    end else begin
      if (slot_commit[S_CTRL]) ctrl_q <= slot_data[S_CTRL] & CTRL_MASK;
      if (slot_commit[S_LOAD]) load_q <= slot_data[S_LOAD];
      if (slot_commit[S_TRIG]) trig_q <= slot_data[S_TRIG];
    end
  end

  kw_key_fsm #(
    .DATA_W (DATA_W)
  ) u_keys (
    .clk      (clk),
    .rst      (rst),
    .commit_i (slot_commit[S_KEY]),
    .key_i    (slot_data[S_KEY]),
    .run_o    (run)
  );

  kw_up_counter #(
    .DATA_W       (DATA_W),
    .DEFAULT_LOAD (DEFAULT_LOAD)
  ) u_cnt (
    .clk           (clk),
    .rst           (rst),
    .tick_en_i     (tick_en),
    .run_i         (run),
    .psc_en_i      (ctrl_q[PSC_EN_B]),
    .psc_exp_i     (ctrl_q[EXP_LO +: EXP_W]),
    .ctrl_commit_i (slot_commit[S_CTRL]),
    .reload_i      (trig_reload),
    .load_i        (load_q),
    .count_o       (count),
    .rst_req_o     (wdt_rst_req)
  );

  always_comb begin
    pend_word = '0;
    for (int i = 0; i < NSLOT; i++) begin
      pend_word[PEND_POS[i]] = slot_pend[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (reg_addr)
        ADDR_W'(A_REV):   rdata_q <= REV_WORD;
        ADDR_W'(A_CTRL):  rdata_q <= ctrl_q & CTRL_MASK;
        ADDR_W'(A_LOAD):  rdata_q <= load_q;
        ADDR_W'(A_COUNT): rdata_q <= count;
        ADDR_W'(A_TRIG):  rdata_q <= trig_q;
        ADDR_W'(A_PEND):  rdata_q <= DATA_W'(pend_word);
        default:          rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;

  // R7: a reload only happens when a trigger lands with a new value
  p_reload_new_value_r7: assert property (@(posedge clk) disable iff (rst)
    trig_reload |=> (trig_q != $past(trig_q)));

  // R3: the reload register only changes on the edge its pending bit clears
  p_load_with_pend_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(load_q) |-> $fell(slot_pend[S_LOAD]));

endmodule

// File: tb/keyseq_wdt_tb_top.sv
`timescale 1ns/1ps
module keyseq_wdt_tb_top;

  localparam logic [31:0] DLOAD = 32'hFFFF_FFC0;
  localparam logic [7:0]  REV   = 8'h5C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wdt_rst_req;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  keyseq_wdt #(
    .DATA_W       (32),
    .ADDR_W       (3),
    .SYNC_TICKS   (2),
    .REV_CODE     (REV),
    .DEFAULT_LOAD (DLOAD)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .wdt_rst_req (wdt_rst_req)
  );

  // Row: do_wr, waddr, wdata, ticks, raddr, expected, requirement number
  localparam int NV = 29;
  localparam logic [86:0] VEC [NV] = '{
    {1'b0, 3'd0, 32'h0,        8'd5, 3'd3, 32'hFFFF_FFC5, 8'd4 },  // R4 plain counting
    {1'b1, 3'd4, 32'h0,        8'd2, 3'd3, 32'hFFFF_FFC7, 8'd7 },  // R7 equal to initial trigger
    {1'b1, 3'd2, 32'h100,      8'd2, 3'd2, 32'h100,       8'd3 },  // R3 reload lands
    {1'b0, 3'd0, 32'h0,        8'd0, 3'd3, 32'hFFFF_FFC9, 8'd4 },  // R4
    {1'b1, 3'd4, 32'h1234,     8'd2, 3'd3, 32'h100,       8'd7 },  // R7 new value reloads
    {1'b1, 3'd4, 32'h1234,     8'd2, 3'd3, 32'h102,       8'd7 },  // R7 same value ignored
    {1'b1, 3'd4, 32'hEDCB,     8'd2, 3'd3, 32'h100,       8'd7 },  // R7 new value reloads
    {1'b1, 3'd3, 32'h55,       8'd0, 3'd3, 32'h100,       8'd11},  // R11 counter read-only
    {1'b1, 3'd1, 32'h28,       8'd2, 3'd3, 32'h102,       8'd5 },  // R5 enable, k=2
    {1'b0, 3'd0, 32'h0,        8'd4, 3'd3, 32'h103,       8'd5 },  // R5
    {1'b0, 3'd0, 32'h0,        8'd3, 3'd3, 32'h103,       8'd5 },  // R5
    {1'b0, 3'd0, 32'h0,        8'd1, 3'd3, 32'h104,       8'd5 },  // R5
    {1'b1, 3'd1, 32'h0,        8'd2, 3'd3, 32'h104,       8'd5 },  // R5 landing tick uses old ratio
    {1'b0, 3'd0, 32'h0,        8'd1, 3'd3, 32'h105,       8'd4 },  // R4
    {1'b1, 3'd5, 32'hAAAA,     8'd2, 3'd3, 32'h107,       8'd8 },  // R8
    {1'b1, 3'd5, 32'h5555,     8'd2, 3'd3, 32'h109,       8'd8 },  // R8 landing tick counts
    {1'b0, 3'd0, 32'h0,        8'd5, 3'd3, 32'h109,       8'd8 },  // R8 stopped
    {1'b1, 3'd5, 32'h4444,     8'd2, 3'd3, 32'h109,       8'd10},  // R10 lone second word
    {1'b1, 3'd5, 32'hBBBB,     8'd2, 3'd3, 32'h109,       8'd10},  // R10
    {1'b1, 3'd5, 32'h1234,     8'd2, 3'd3, 32'h109,       8'd10},  // R10 intervening word
    {1'b1, 3'd5, 32'h4444,     8'd3, 3'd3, 32'h109,       8'd10},  // R10
    {1'b1, 3'd5, 32'hBBBB,     8'd2, 3'd3, 32'h109,       8'd9 },  // R9
    {1'b1, 3'd5, 32'h4444,     8'd2, 3'd3, 32'h109,       8'd9 },  // R9 landing tick idle
    {1'b0, 3'd0, 32'h0,        8'd3, 3'd3, 32'h10C,       8'd9 },  // R9 running
    {1'b1, 3'd5, 32'hAAAA,     8'd2, 3'd3, 32'h10E,       8'd10},  // R10
    {1'b1, 3'd5, 32'hBBBB,     8'd2, 3'd3, 32'h110,       8'd10},  // R10
    {1'b1, 3'd5, 32'h5555,     8'd2, 3'd3, 32'h112,       8'd10},  // R10 mismatched pair
    {1'b0, 3'd0, 32'h0,        8'd1, 3'd3, 32'h113,       8'd10},  // R10 still running
    {1'b1, 3'd0, 32'hFF,       8'd0, 3'd0, 32'h5C,        8'd2 }   // R2 revision, write ignored
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(1, {31'b0, wdt_rst_req}, 32'h0);
    rd(3'd3, v); chk(1, v, DLOAD);
    rd(3'd2, v); chk(1, v, DLOAD);
    rd(3'd1, v); chk(1, v, 32'h0);
    rd(3'd6, v); chk(1, v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][86]) wr(VEC[i][85:83], VEC[i][82:51]);
      for (int t = 0; t < int'(VEC[i][50:43]); t++) tick();
      rd(VEC[i][42:40], v);
      chk(int'(VEC[i][7:0]), v, VEC[i][39:8]);
    end

    // R3 pending bits and restart of a posted write
    wr(3'd2, 32'h200);
    rd(3'd6, v); chk(3, v, 32'h04);
    tick();
    rd(3'd6, v); chk(3, v, 32'h04);
    rd(3'd2, v); chk(3, v, 32'h100);
    wr(3'd2, 32'h300);
    tick();
    rd(3'd6, v); chk(3, v, 32'h04);
    rd(3'd2, v); chk(3, v, 32'h100);
    tick();
    rd(3'd6, v); chk(3, v, 32'h00);
    rd(3'd2, v); chk(3, v, 32'h300);
    rd(3'd3, v); chk(4, v, 32'h116);
    wr(3'd1, 32'h0);
    rd(3'd6, v); chk(3, v, 32'h01);
    wr(3'd4, 32'hEDCB);
    rd(3'd6, v); chk(3, v, 32'h09);
    wr(3'd5, 32'h0);
    rd(3'd6, v); chk(3, v, 32'h19);
    tick(); tick();
    rd(3'd6, v); chk(3, v, 32'h00);
    rd(3'd3, v); chk(7, v, 32'h118);

    // R6 wrap, reset request and reload
    wr(3'd2, 32'hFFFF_FFFA);
    tick(); tick();
    wr(3'd4, 32'h5A5A);
    tick(); tick();
    rd(3'd3, v); chk(7, v, 32'hFFFF_FFFA);
    for (int t = 0; t < 5; t++) begin
      tick();
      chk(6, {31'b0, wdt_rst_req}, 32'h0);
    end
    rd(3'd3, v); chk(6, v, 32'hFFFF_FFFF);
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    chk(6, {31'b0, wdt_rst_req}, 32'h1);
    @(negedge clk);
    chk(6, {31'b0, wdt_rst_req}, 32'h0);
    rd(3'd3, v); chk(6, v, 32'hFFFF_FFFA);

    // R12 registered read path
    @(negedge clk);
    reg_addr = 3'd0;
    @(negedge clk);
    chk(12, reg_rdata, 32'h5C);
    reg_addr = 3'd2;
    #1;
    chk(12, reg_rdata, 32'h5C);
    @(negedge clk);
    chk(12, reg_rdata, 32'hFFFF_FFFA);

    report();
  end

endmodule